// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address that a pipelined memory array sees during a four-beat burst. When an access starts, a load strobe captures the full external address. That address is issued unchanged as the first beat. Each later clock with the advance input high steps to the next beat. Only the two least significant address bits move. The bits above them stay at the captured value for the whole burst.

A mode input picks the beat order at run time. When it is high, the order is interleaved: the low bits are the starting low bits XOR the beat number. When it is low, the order is linear: the low bits count up modulo four from the starting value. With advance low, the current beat is held, so the burst is suspended. Advancing past the fourth beat wraps back to the first address of the burst. A load that arrives mid-burst discards the old burst and starts a new one.

The control is a small state machine with five named states:
- `ST_IDLE`: no burst has been loaded since reset.
- `ST_BEAT0`, `ST_BEAT1`, `ST_BEAT2`, `ST_BEAT3`: the current beat of a loaded burst.

Its transitions are:
- LOAD: any state goes to `ST_BEAT0` when `load` is high.
- STEP: `ST_BEATn` goes to `ST_BEATn+1` when `advance` is high.
- WRAP: `ST_BEAT3` goes to `ST_BEAT0` when `advance` is high.
- HOLD: every state stays put when neither `load` nor `advance` is high.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `addr_out` reads all zeros.
- R2: One clock edge after `load` is sampled high, `addr_out` equals the `addr_in` value sampled at that edge.
- R3: With `order_sel` = 1 (interleaved), the low two bits of beat k (k = 0..3) equal the starting low bits XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R4: With `order_sel` = 0 (linear), the low two bits of beat k equal the starting low bits plus k, modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R5: Once a burst is loaded, bits ADDR_W-1 down to 2 of `addr_out` do not change until the next load. `addr_in` is ignored on every edge where `load` is low.
- R6: An edge with both `load` and `advance` low leaves `addr_out` unchanged, which suspends the burst.
- R7: An advance taken on the fourth beat returns `addr_out` to the first address of the burst.
- R8: A load during a burst replaces the base address and restarts at beat 0.
- R9: When `load` and `advance` are both high on one edge, the load wins. The result is beat 0 of the new address.
- R10: Before the first load after reset, `advance` has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Starts a burst from `addr_in` |
| advance | input | 1 | Steps to the next beat of the burst |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Internal address of the current beat |

## Verification
The assertions treat `order_sel` as a static strap. They assume it changes only on an edge where `load` is high, because `addr_out` decodes the beat order combinationally from the live mode. The hold and ordering properties therefore require the mode to be unchanged between the two edges they compare. The stimulus respects this: it changes `order_sel` only together with a load. Between loads it drives junk on `addr_in`, so that the pass-through of the upper bits is really tested.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } beat_state_t;

    function automatic logic [BEAT_W-1:0] beat_of(input beat_state_t st);
        logic [BEAT_W-1:0] idx;
        unique case (st)
            ST_BEAT1: idx = 2'd1;
            ST_BEAT2: idx = 2'd2;
            ST_BEAT3: idx = 2'd3;
            default:  idx = 2'd0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    output logic [BEAT_W-1:0]   beat
);

    beat_state_t state_q;
    beat_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else if (advance) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat = beat_of(state_q);
    end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 18,
    parameter int LO_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
        end else if (load) begin
            base <= addr_in;
        end
    end

endmodule

// File: rtl/burst_lo_gen.sv
module burst_lo_gen #(
    parameter int LO_W = 2
) (
    input  logic [LO_W-1:0] start_lo,
    input  logic [LO_W-1:0] beat,
    input  logic            order_sel,
    output logic [LO_W-1:0] lo_out
);

    logic [LO_W-1:0] lo_xor;
    logic [LO_W-1:0] lo_add;

    always_comb begin
        lo_xor = start_lo ^ beat;
        lo_add = start_lo + beat;
        lo_out = order_sel ? lo_xor : lo_add;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] lo_now;

    burst_beat_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .beat    (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W), .LO_W(BEAT_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .base    (base)
    );

    burst_lo_gen #(.LO_W(BEAT_W)) u_lo (
        .start_lo  (base[BEAT_W-1:0]),
        .beat      (beat),
        .order_sel (order_sel),
        .lo_out    (lo_now)
    );

    always_comb begin
        addr_out = {base[ADDR_W-1 -: HI_W], lo_now};
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);

    logic       loaded;
    logic [1:0] start_lo;
    logic [1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded   <= 1'b0;
            start_lo <= 2'd0;
            cnt      <= 2'd0;
        end else if (load) begin
            loaded   <= 1'b1;
            start_lo <= addr_in[1:0];
            cnt      <= 2'd0;
        end else if (advance && loaded) begin
            cnt      <= cnt + 2'd1;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && advance) |=> addr_out[1:0] == $past(addr_in[1:0]));

    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) ##1 $stable(order_sel) |-> $stable(addr_out));

    assert_interleave_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && order_sel) |-> addr_out[1:0] == (start_lo ^ cnt));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !load && advance && !order_sel) ##1 !order_sel
            |-> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && !load) |=> addr_out == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .advance   (advance),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NV = 22;

    // vector fields: {load, advance, order_sel, addr_in[7:0], expected[7:0]}
    localparam logic [18:0] VEC [NV] = '{
        {3'b101, 8'h51, 8'h51},
        {3'b011, 8'h00, 8'h50},
        {3'b011, 8'hAA, 8'h53},
        {3'b011, 8'h00, 8'h52},
        {3'b011, 8'h00, 8'h51},
        {3'b001, 8'h3C, 8'h51},
        {3'b011, 8'h00, 8'h50},
        {3'b111, 8'hA6, 8'hA6},
        {3'b011, 8'h00, 8'hA7},
        {3'b100, 8'h32, 8'h32},
        {3'b010, 8'h00, 8'h33},
        {3'b000, 8'hC5, 8'h33},
        {3'b010, 8'h00, 8'h30},
        {3'b010, 8'h00, 8'h31},
        {3'b010, 8'h00, 8'h32},
        {3'b100, 8'hFF, 8'hFF},
        {3'b010, 8'h00, 8'hFC},
        {3'b101, 8'hFF, 8'hFF},
        {3'b011, 8'h11, 8'hFE},
        {3'b011, 8'h00, 8'hFD},
        {3'b011, 8'h00, 8'hFC},
        {3'b011, 8'h00, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(input int i);
        case (i)
            0, 15, 17:                 return "R2";
            4, 14, 21:                 return "R7";
            5, 11:                     return "R6";
            7:                         return "R9";
            9:                         return "R8";
            10, 12, 13:                return "R4";
            16:                        return "R5";
            default:                   return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        check("R1", addr_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", addr_out, 8'h00);
        // R10: advance without any load changes nothing
        advance = 1'b1;
        addr_in = 8'h9B;
        @(negedge clk);
        @(negedge clk);
        check("R10", addr_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {load, advance, order_sel} = VEC[i][18:16];
            addr_in = VEC[i][15:8];
            @(negedge clk);
            check(tag_of(i), addr_out, VEC[i][7:0]);
        end

        // R6: long suspension keeps the address
        load = 1'b0;
        advance = 1'b0;
        addr_in = 8'h77;
        for (int k = 0; k < 5; k++) @(negedge clk);
        check("R6", addr_out, 8'hFF);

        // R1: reset mid-burst clears the address
        advance = 1'b1;
        @(negedge clk);
        check("R3", addr_out, 8'hFE);
        rst_n = 1'b0;
        #1;
        check("R1", addr_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        advance = 1'b0;
        @(negedge clk);
        check("R1", addr_out, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule